// File: doc/BRIEF.md
# Endpoint FIFO DMA Request Controller

This block sits between a byte-wide parallel host bus and the endpoint FIFOs of a USB device controller and runs the handshake with an external fly-by DMA engine. Software picks one endpoint as the DMA partner through a control register. The block then raises a request line whenever that endpoint's FIFO can give or take a byte. Each acknowledged strobe moves exactly one byte between the bus and the FIFO, at an address the block works out for itself.

Endpoints 1 to 6 can be chosen. Odd-numbered endpoints are transmit FIFOs, filled by DMA writes. Even-numbered endpoints are receive FIFOs, drained by DMA reads. A CPU access with chip select always wins over the acknowledge line. DMA is allowed only when the device is strapped for the parallel bus.

Top module: `ep_dma_req`

## Requirements
- R1: After a synchronous reset, `drq`, `fifo_pop`, `fifo_push`, `rdata` and `tx_byte` are all zero. The control register reads as 8'h10 (endpoint 1, everything else off) and the status register reads as 0.
- R2: The control register sits at address 0. Its fields are bit 0 DMA enable, bit 1 request enable, bit 2 mode (0 immediate, 1 event), bit 3 warning enable and bits 6:4 endpoint. A CPU write whose endpoint field is 0 or greater than 6 keeps the previous endpoint but still updates the other fields.
- R3: In immediate mode, with enable, request enable and `par_mode` all high, `drq` is high while the selected receive FIFO (even endpoint) is not empty, or while the selected transmit FIFO (odd endpoint) is not full.
- R4: In event mode, `drq` is high only when the FIFO can move a byte and either the endpoint's `fifo_done` is high or both its `fifo_warn` and the warning-enable bit are high.
- R5: The FIFO status of endpoints that are not selected has no effect on `drq`.
- R6: While `par_mode` is low, `drq` stays low and acknowledged strobes move no byte.
- R7: The rising edge of `rd_stb` with `dack` high, `cs` low and an even endpoint selected pops one byte, and that byte appears on `rdata`. The rising edge of `wr_stb` with an odd endpoint selected pushes `wdata` into the transmit FIFO through `tx_byte`. `addr` plays no part in either.
- R8: A strobe held high for several clocks moves only one byte.
- R9: While `cs` is high, `dack` is ignored. The strobe performs a register access and pops or pushes nothing.
- R10: `drq` falls no later than two clocks after the strobe edge that takes the last byte from a receive FIFO or fills a transmit FIFO.
- R11: Clearing request enable drops `drq` one clock later. The exception is a write made while an acknowledged cycle is still open (`dack` has stayed high since the transfer): then `drq` holds until `dack` falls.
- R12: The status register at address 1 has bit 0 set by any DMA byte transfer. Every write to the control register clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| par_mode | input | 1 | Strap: high when the parallel bus interface is in use |
| cs | input | 1 | CPU chip select, active high |
| rd_stb | input | 1 | Read strobe, active high |
| wr_stb | input | 1 | Write strobe, active high |
| dack | input | 1 | DMA acknowledge, active high |
| addr | input | 2 | Register address, used only for CPU accesses |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Registered bus read data |
| drq | output | 1 | Registered DMA request |
| fifo_empty | input | 6 | Per endpoint: receive FIFO empty |
| fifo_full | input | 6 | Per endpoint: transmit FIFO full |
| fifo_warn | input | 6 | Per endpoint: FIFO warning level reached |
| fifo_done | input | 6 | Per endpoint: reception or transmission complete |
| rx_data | input | 48 | Head byte of each receive FIFO, endpoint 1 in bits 7:0 |
| fifo_pop | output | 6 | One-clock pop pulse, one-hot per endpoint |
| fifo_push | output | 6 | One-clock push pulse, one-hot per endpoint |
| tx_byte | output | 8 | Byte being pushed into the transmit FIFO |

## Verification
The hardest case to reach from the ports is a halt that arrives inside an open DMA cycle. The request must outlive the cleared enable bit, and that can only happen when a chip-select write lands while `dack` is still high after a completed byte. The stimulus holds `dack` high, finishes a read strobe, then asserts `cs` with a write that clears request enable, and keeps `dack` up for a few more clocks before dropping it. A reference model in the bench follows every register and the FIFO fill levels clock by clock, so the moment at which the request falls is compared exactly.

// File: rtl/ep_dma_pkg.sv
package ep_dma_pkg;
  localparam int DATA_W = 8;
  localparam int SRC_W  = 3;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_STAT = 2'd1;

  typedef enum logic {
    MODE_IMM = 1'b0,
    MODE_EVT = 1'b1
  } req_mode_t;

  typedef struct packed {
    logic             rsvd;
    logic [SRC_W-1:0] src;
    logic             warn_en;
    req_mode_t        mode;
    logic             req_en;
    logic             en;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{rsvd: 1'b0, src: 3'd1, warn_en: 1'b0,
                                 mode: MODE_IMM, req_en: 1'b0, en: 1'b0};
endpackage

// File: rtl/ep_dma_regs.sv
module ep_dma_regs
  import ep_dma_pkg::*;
#(
  parameter int NUM_EP = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              xfer,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] reg_rdata
);
  ctrl_t            ctrl_q;
  logic             flag_q;
  ctrl_t            wr_view;
  logic             src_ok;

  assign wr_view = ctrl_t'(wdata);
  assign src_ok  = (wr_view.src != '0) && (int'(wr_view.src) <= NUM_EP);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RST;
      flag_q <= 1'b0;
    end else begin
      if (wr_en && addr == ADR_CTRL) begin
        ctrl_q.en      <= wr_view.en;
        ctrl_q.req_en  <= wr_view.req_en;
        ctrl_q.mode    <= wr_view.mode;
        ctrl_q.warn_en <= wr_view.warn_en;
        if (src_ok) ctrl_q.src <= wr_view.src;
        flag_q <= 1'b0;
      end else if (xfer) begin
        flag_q <= 1'b1;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (addr == ADR_CTRL)      reg_rdata = DATA_W'(ctrl_q);
    else if (addr == ADR_STAT) reg_rdata = {{(DATA_W-1){1'b0}}, flag_q};
  end

  assign ctrl = ctrl_q;

  AST_SRC_RANGE: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.src != '0) && (int'(ctrl_q.src) <= NUM_EP)); // R2
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADR_CTRL) |=> !flag_q); // R12
endmodule

// File: rtl/ep_dma_strobe.sv
module ep_dma_strobe (
  input  logic clk,
  input  logic rst,
  input  logic rd_stb,
  input  logic wr_stb,
  output logic rd_rise,
  output logic wr_rise
);
  logic rd_q, wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= rd_stb;
      wr_q <= wr_stb;
    end
  end

  assign rd_rise = rd_stb && !rd_q;
  assign wr_rise = wr_stb && !wr_q;
endmodule

// File: rtl/ep_dma_reqgen.sv
module ep_dma_reqgen
  import ep_dma_pkg::*;
#(
  parameter int NUM_EP = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              par_mode,
  input  ctrl_t             ctrl,
  input  logic [NUM_EP-1:0] fifo_empty,
  input  logic [NUM_EP-1:0] fifo_full,
  input  logic [NUM_EP-1:0] fifo_warn,
  input  logic [NUM_EP-1:0] fifo_done,
  input  logic              busy,
  input  logic              dack,
  output logic              drq
);
  logic [NUM_EP-1:0] want;
  logic [SRC_W-1:0]  ep_idx;
  logic              want_sel;
  logic              drq_q;
  logic              hold;

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    logic avail;
    logic event_hit;
    if (e % 2 == 0) begin : g_tx
      assign avail = !fifo_full[e];
    end else begin : g_rx
      assign avail = !fifo_empty[e];
    end
    assign event_hit = fifo_done[e] || (ctrl.warn_en && fifo_warn[e]);
    assign want[e]   = (ctrl.mode == MODE_EVT) ? (avail && event_hit) : avail;
  end

  assign ep_idx   = ctrl.src - SRC_W'(1);
  assign want_sel = want[ep_idx];
  assign hold     = drq_q && busy && dack;

  always_ff @(posedge clk) begin
    if (rst) drq_q <= 1'b0;
    else     drq_q <= par_mode && ctrl.en && want_sel && (ctrl.req_en || hold);
  end

  assign drq = drq_q;

  AST_NO_DRQ_WITHOUT_PAR: assert property (@(posedge clk) disable iff (rst)
    !par_mode |=> !drq_q); // R6
  AST_HALT_DROPS: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.req_en && !(busy && dack)) |=> !drq_q); // R11
endmodule

// File: rtl/ep_dma_req.sv
module ep_dma_req
  import ep_dma_pkg::*;
#(
  parameter int NUM_EP = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     par_mode,
  input  logic                     cs,
  input  logic                     rd_stb,
  input  logic                     wr_stb,
  input  logic                     dack,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata,
  output logic                     drq,
  input  logic [NUM_EP-1:0]        fifo_empty,
  input  logic [NUM_EP-1:0]        fifo_full,
  input  logic [NUM_EP-1:0]        fifo_warn,
  input  logic [NUM_EP-1:0]        fifo_done,
  input  logic [NUM_EP*DATA_W-1:0] rx_data,
  output logic [NUM_EP-1:0]        fifo_pop,
  output logic [NUM_EP-1:0]        fifo_push,
  output logic [DATA_W-1:0]        tx_byte
);
  ctrl_t              ctrl;
  logic [DATA_W-1:0]  reg_rdata;
  logic               rd_rise, wr_rise;
  logic               cpu_rd, cpu_wr;
  logic               dma_ok, is_tx;
  logic               dma_rd, dma_wr, xfer;
  logic [SRC_W-1:0]   ep_idx;
  logic [NUM_EP-1:0]  sel_oh;
  logic [DATA_W-1:0]  rx_byte;
  logic               busy_q;
  logic [NUM_EP-1:0]  pop_q, push_q;
  logic [DATA_W-1:0]  rdata_q, tx_q;

  ep_dma_strobe u_strobe (
    .clk     (clk),
    .rst     (rst),
    .rd_stb  (rd_stb),
    .wr_stb  (wr_stb),
    .rd_rise (rd_rise),
    .wr_rise (wr_rise)
  );

  assign cpu_rd = cs && rd_rise;
  assign cpu_wr = cs && wr_rise;

  ep_dma_regs #(.NUM_EP(NUM_EP)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (cpu_wr),
    .addr      (addr),
    .wdata     (wdata),
    .xfer      (xfer),
    .ctrl      (ctrl),
    .reg_rdata (reg_rdata)
  );

  assign ep_idx = ctrl.src - SRC_W'(1);
  assign sel_oh = NUM_EP'(1) << ep_idx;
  assign is_tx  = ctrl.src[0];
  assign dma_ok = par_mode && ctrl.en && !cs && dack;

  always_comb begin
    rx_byte = '0;
    for (int i = 0; i < NUM_EP; i++) begin
      if (ep_idx == SRC_W'(i)) rx_byte = rx_data[i*DATA_W +: DATA_W];
    end
  end

  assign dma_rd = dma_ok && rd_rise && !is_tx && !fifo_empty[ep_idx];
  assign dma_wr = dma_ok && wr_rise &&  is_tx && !fifo_full[ep_idx];
  assign xfer   = dma_rd || dma_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      pop_q   <= '0;
      push_q  <= '0;
      rdata_q <= '0;
      tx_q    <= '0;
      busy_q  <= 1'b0;
    end else begin
      pop_q  <= dma_rd ? sel_oh : '0;
      push_q <= dma_wr ? sel_oh : '0;
      busy_q <= xfer || (busy_q && dack);
      if (cpu_rd)      rdata_q <= reg_rdata;
      else if (dma_rd) rdata_q <= rx_byte;
      if (dma_wr) tx_q <= wdata;
    end
  end

  ep_dma_reqgen #(.NUM_EP(NUM_EP)) u_reqgen (
    .clk        (clk),
    .rst        (rst),
    .par_mode   (par_mode),
    .ctrl       (ctrl),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .fifo_warn  (fifo_warn),
    .fifo_done  (fifo_done),
    .busy       (busy_q),
    .dack       (dack),
    .drq        (drq)
  );

  assign fifo_pop  = pop_q;
  assign fifo_push = push_q;
  assign rdata     = rdata_q;
  assign tx_byte   = tx_q;

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pop_q, push_q})); // R7
  AST_ONE_BYTE_PER_EDGE: assert property (@(posedge clk) disable iff (rst)
    (|pop_q || |push_q) |=> !(|pop_q || |push_q)); // R8
  AST_CS_OVERRIDES: assert property (@(posedge clk) disable iff (rst)
    cs |=> (pop_q == '0 && push_q == '0)); // R9
  AST_PAR_GATES_XFER: assert property (@(posedge clk) disable iff (rst)
    !par_mode |=> (pop_q == '0 && push_q == '0)); // R6
endmodule

// File: tb/ep_dma_req_bench.sv
module ep_dma_req_bench;
  localparam int NEP   = 6;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic par_mode = 1'b1;
  logic cs = 1'b0, rd = 1'b0, wr = 1'b0, dack = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata, tx_byte;
  logic drq;
  logic [NEP-1:0] f_empty, f_full, f_warn, f_done, pop, push;
  logic [NEP*8-1:0] rx_data;

  int rx_cnt[NEP], rx_popped[NEP], tx_cnt[NEP];
  int checks = 0, errors = 0;
  bit done = 0, cmp_on = 0;
  string phase = "R1";

  // reference model state
  bit m_en, m_req, m_mode, m_warn, m_flag, m_rdq, m_wrq, m_drq, m_busy;
  int m_src, m_pop, m_push;
  logic [7:0] m_rdata, m_txb;

  always #5 clk = ~clk;

  ep_dma_req u_ep_dma_req (
    .clk(clk), .rst(rst), .par_mode(par_mode), .cs(cs), .rd_stb(rd), .wr_stb(wr),
    .dack(dack), .addr(addr), .wdata(wdata), .rdata(rdata), .drq(drq),
    .fifo_empty(f_empty), .fifo_full(f_full), .fifo_warn(f_warn), .fifo_done(f_done),
    .rx_data(rx_data), .fifo_pop(pop), .fifo_push(push), .tx_byte(tx_byte)
  );

  always_comb begin
    for (int i = 0; i < NEP; i++) begin
      f_empty[i] = (rx_cnt[i] == 0);
      f_full[i]  = (tx_cnt[i] == DEPTH);
      rx_data[i*8 +: 8] = 8'((i + 1) * 32 + rx_popped[i]);
    end
  end

  always @(posedge clk) begin
    bit rr, wrr, tx, avail, want, drd, dwr, n_drq, n_busy;
    int ep;
    if (m_pop >= 0) begin
      rx_cnt[m_pop]    <= rx_cnt[m_pop] - 1;
      rx_popped[m_pop] <= rx_popped[m_pop] + 1;
    end
    if (m_push >= 0) tx_cnt[m_push] <= tx_cnt[m_push] + 1;
    if (rst) begin
      m_en = 0; m_req = 0; m_mode = 0; m_warn = 0; m_src = 1; m_flag = 0;
      m_rdq = 0; m_wrq = 0; m_drq = 0; m_busy = 0; m_pop = -1; m_push = -1;
      m_rdata = 0; m_txb = 0;
    end else begin
      rr  = rd && !m_rdq;
      wrr = wr && !m_wrq;
      ep  = m_src - 1;
      tx  = (m_src % 2) == 1;
      avail = tx ? (tx_cnt[ep] != DEPTH) : (rx_cnt[ep] != 0);
      want  = m_mode ? (avail && (f_done[ep] || (m_warn && f_warn[ep]))) : avail;
      drd = !cs && dack && rr && par_mode && m_en && !tx && rx_cnt[ep] != 0;
      dwr = !cs && dack && wrr && par_mode && m_en && tx && tx_cnt[ep] != DEPTH;
      n_drq  = par_mode && m_en && want && (m_req || (m_drq && m_busy && dack));
      n_busy = drd || dwr || (m_busy && dack);
      if (cs && rr)
        m_rdata = (addr == 0) ? {1'b0, 3'(m_src), m_warn, m_mode, m_req, m_en}
                : (addr == 1) ? {7'd0, m_flag} : 8'd0;
      else if (drd)
        m_rdata = 8'((ep + 1) * 32 + rx_popped[ep]);
      if (dwr) m_txb = wdata;
      m_pop  = drd ? ep : -1;
      m_push = dwr ? ep : -1;
      if (cs && wrr && addr == 0) begin
        m_en = wdata[0]; m_req = wdata[1]; m_mode = wdata[2]; m_warn = wdata[3];
        if (wdata[6:4] >= 1 && wdata[6:4] <= NEP) m_src = int'(wdata[6:4]);
        m_flag = 0;
      end else if (drd || dwr) m_flag = 1;
      m_rdq = rd; m_wrq = wr; m_drq = n_drq; m_busy = n_busy;
    end
  end

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      check(phase, "drq", {7'd0, drq}, {7'd0, m_drq});
      check(phase, "pop", {2'd0, pop}, (m_pop >= 0) ? 8'(1 << m_pop) : 8'd0);
      check(phase, "push", {2'd0, push}, (m_push >= 0) ? 8'(1 << m_push) : 8'd0);
      check(phase, "rdata", rdata, m_rdata);
      check(phase, "tx_byte", tx_byte, m_txb);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cpu_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); cs = 1; addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0; cs = 0;
  endtask

  task automatic cpu_rd(logic [1:0] a, logic [7:0] exp, string req);
    @(negedge clk); cs = 1; addr = a; rd = 1;
    @(negedge clk); rd = 0; cs = 0;
    check(req, "register read", rdata, exp);
  endtask

  task automatic dma_read(int hold, logic [7:0] exp, string req);
    @(negedge clk); dack = 1; rd = 1; addr = 2'd3;
    tick(hold);
    rd = 0;
    check(req, "dma read byte", rdata, exp);
    @(negedge clk); dack = 0;
  endtask

  task automatic dma_write(int hold, logic [7:0] d);
    @(negedge clk); dack = 1; wr = 1; wdata = d; addr = 2'd2;
    tick(hold);
    wr = 0;
    @(negedge clk); dack = 0;
  endtask

  initial begin
    for (int i = 0; i < NEP; i++) begin
      rx_cnt[i] <= 0; rx_popped[i] <= 0; tx_cnt[i] <= 0;
    end
    f_warn = '0; f_done = '0;
    m_pop = -1; m_push = -1;
    tick(3);
    rst = 0;
    tick(1);
    cmp_on = 1;
    // R1 reset state
    check("R1", "drq after reset", {7'd0, drq}, 8'd0);
    check("R1", "pop after reset", {2'd0, pop}, 8'd0);
    cpu_rd(2'd0, 8'h10, "R1");
    cpu_rd(2'd1, 8'h00, "R1");
    // R2 endpoint field rejection
    phase = "R2";
    cpu_wr(2'd0, 8'h01); cpu_rd(2'd0, 8'h11, "R2");
    cpu_wr(2'd0, 8'h41); cpu_rd(2'd0, 8'h41, "R2");
    cpu_wr(2'd0, 8'h73); cpu_rd(2'd0, 8'h43, "R2");
    cpu_wr(2'd0, 8'h01); cpu_rd(2'd0, 8'h41, "R2");
    // R5 other endpoints ignored, R3 immediate request on receive endpoint 2
    phase = "R5";
    cpu_wr(2'd0, 8'h23);
    @(negedge clk); rx_cnt[3] <= 4; tx_cnt[0] <= 0; f_done = 6'h3d;
    tick(3);
    check("R5", "drq with only other endpoints ready", {7'd0, drq}, 8'd0);
    f_done = '0;
    phase = "R3";
    rx_cnt[1] <= 3;
    tick(2);
    check("R3", "drq on non-empty rx", {7'd0, drq}, 8'd1);
    // R7, R8 single pop per held strobe, address ignored
    phase = "R8";
    dma_read(3, 8'h40, "R7");
    check("R8", "rx level after held strobe", 8'(rx_cnt[1]), 8'd2);
    // R10 drain to empty
    phase = "R10";
    dma_read(1, 8'h41, "R7");
    dma_read(1, 8'h42, "R7");
    tick(1);
    check("R10", "drq after last byte", {7'd0, drq}, 8'd0);
    // R12 status flag
    phase = "R12";
    cpu_rd(2'd1, 8'h01, "R12");
    cpu_wr(2'd0, 8'h23);
    cpu_rd(2'd1, 8'h00, "R12");
    // transmit endpoint 1
    phase = "R3";
    cpu_wr(2'd0, 8'h13);
    @(negedge clk); tx_cnt[0] <= DEPTH - 1;
    tick(2);
    check("R3", "drq on non-full tx", {7'd0, drq}, 8'd1);
    phase = "R7";
    dma_write(2, 8'hA5);
    check("R7", "tx byte", tx_byte, 8'hA5);
    check("R7", "tx level", 8'(tx_cnt[0]), 8'(DEPTH));
    tick(2);
    check("R10", "drq after tx full", {7'd0, drq}, 8'd0);
    // R9 chip select beats acknowledge
    phase = "R9";
    cpu_wr(2'd0, 8'h23);
    @(negedge clk); rx_cnt[1] <= 2;
    @(negedge clk); cs = 1; dack = 1; rd = 1; addr = 2'd0;
    @(negedge clk); rd = 0; cs = 0; dack = 0;
    check("R9", "cs read during dack", rdata, 8'h23);
    tick(1);
    check("R9", "rx level unchanged", 8'(rx_cnt[1]), 8'd2);
    // R4 event mode
    phase = "R4";
    cpu_wr(2'd0, 8'h27);
    @(negedge clk); f_warn = 6'h02;
    tick(2);
    check("R4", "warn without enable", {7'd0, drq}, 8'd0);
    cpu_wr(2'd0, 8'h2F);
    tick(2);
    check("R4", "warn with enable", {7'd0, drq}, 8'd1);
    f_warn = '0;
    tick(2);
    check("R4", "no event", {7'd0, drq}, 8'd0);
    f_done = 6'h02;
    tick(2);
    check("R4", "done event", {7'd0, drq}, 8'd1);
    f_done = '0;
    // R11 halt inside an open cycle
    phase = "R11";
    cpu_wr(2'd0, 8'h23);
    tick(2);
    @(negedge clk); dack = 1; rd = 1;
    @(negedge clk); rd = 0;
    @(negedge clk); cs = 1; addr = 2'd0; wdata = 8'h21; wr = 1;
    @(negedge clk); wr = 0; cs = 0;
    tick(2);
    check("R11", "drq held while dack open", {7'd0, drq}, 8'd1);
    dack = 0;
    tick(2);
    check("R11", "drq after dack falls", {7'd0, drq}, 8'd0);
    cpu_wr(2'd0, 8'h23);
    tick(2);
    cpu_wr(2'd0, 8'h21);
    tick(1);
    check("R11", "plain halt", {7'd0, drq}, 8'd0);
    // R6 serial strap
    phase = "R6";
    cpu_wr(2'd0, 8'h23);
    @(negedge clk); par_mode = 0;
    tick(2);
    check("R6", "drq without parallel mode", {7'd0, drq}, 8'd0);
    @(negedge clk); dack = 1; rd = 1;
    @(negedge clk); rd = 0; dack = 0;
    tick(1);
    check("R6", "rx level unchanged", 8'(rx_cnt[1]), 8'd1);
    par_mode = 1;
    tick(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule